// File: doc/BRIEF.md
# Serial Character Receiver with Flagged Receive Queue

This block receives asynchronous serial characters on one line. It samples the line on an external 16x oversampling enable and builds characters of 5 to 8 data bits. A character may carry a parity bit, which the block checks, compares to a forced value, or reports as an address marker. Each finished character enters a four-entry queue together with its own break, framing and parity flags. A consumer reads the head of the queue through a read strobe and sees a status byte and one receive interrupt.

A mode input sets how the error flags in the status byte behave. In per-character mode they belong to the character at the head and leave the status byte when that character is read. In block mode they are the OR of the flags of every character queued since the last error-reset command, so the consumer can check a whole message once at its end. A receiver-reset command empties the queue, clears all error state and aborts any frame in progress.

The framing state machine has six states. IDLE goes to START on a low sample. START goes to DATA when the start bit is still low at its centre, or back to IDLE if it is not. DATA goes to PARITY after the last data bit when a parity bit is configured, and to STOP otherwise. PARITY goes to STOP. STOP goes to IDLE on a high stop bit or to HOLD on a low one. HOLD goes back to IDLE once the line reads high.

Top module: `uart_rx_chan`

## Requirements
- R1: After reset, status reads 8'h00, rx_irq is 0 and rd_data is 0.
- R2: A start bit is accepted only if the line is still low 8 enables after the low level was first seen. Data bits are then sampled every 16 enables, LSB first. cfg_len sets the character length: 2'b00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits above the length read as 0 in rd_data.
- R3: cfg_par_mode sets the parity handling. 2'b00 checks parity, with cfg_par_odd 0 for even (data plus parity bit have an even count of ones) and 1 for odd. 2'b01 flags an error when the parity bit differs from cfg_par_odd. 2'b10 means no parity bit. 2'b11 (multidrop) reports the received parity bit itself in the parity flag.
- R4: A low stop-bit sample sets the framing flag. A character whose data bits, parity bit (if any) and stop bit all sample low also sets the break flag. After a low stop bit, no new start is searched for until the line reads high.
- R5: The queue holds up to 4 characters in arrival order. A read strobe removes the head character. A read strobe while the queue is empty has no effect. rd_data is 0 when the queue is empty.
- R6: When a character completes while 4 characters are queued (and no read happens in that cycle), the overrun bit sets, the new character is dropped and the queued characters are kept. Overrun stays set until an error-reset or receiver-reset command.
- R7: Status byte layout: bit 7 break, bit 6 framing, bit 5 parity, bit 4 overrun, bits 3:2 always 0, bit 1 queue full (4 entries), bit 0 at least one character ready.
- R8: With cfg_blk_mode=0, status bits 7:5 are the flags of the head character, and they are 0 when the queue is empty.
- R9: With cfg_blk_mode=1, status bits 7:5 are the OR of the flags of all characters queued since the last error-reset or receiver-reset. They fall only through one of those commands, and cmd_err_clr clears them one cycle after it is asserted.
- R10: cmd_rx_rst empties the queue and clears the overrun bit and the accumulated flags. One cycle after it, status is 8'h00.
- R11: rx_irq follows the ready bit when cfg_irq_full=0 and the full bit when cfg_irq_full=1.
- R12: A low pulse shorter than half a bit that is high again at the start-bit centre produces no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len | input | 2 | Character length code |
| cfg_par_mode | input | 2 | Parity handling code |
| cfg_par_odd | input | 1 | Odd parity select, or forced parity value |
| cfg_blk_mode | input | 1 | 0 = per-character flags, 1 = accumulated flags |
| cfg_irq_full | input | 1 | 0 = interrupt on ready, 1 = interrupt on full |
| rd_en | input | 1 | Read strobe, removes the head character |
| cmd_err_clr | input | 1 | Error-reset command pulse |
| cmd_rx_rst | input | 1 | Receiver-reset command pulse |
| rd_data | output | 8 | Head character data |
| status | output | 8 | Status byte |
| rx_irq | output | 1 | Receive interrupt |

## Verification
A wrong bit counter or a wrong sampling point corrupts rd_data or the parity and framing flags at the very next character. That happens within one frame time, about 160 enables. A corrupted queue pointer or count shows up in the ready and full bits, and in the order of rd_data on the next read, within a cycle of the read or write that caused it. An accumulator or overrun bit that clears too early or too late is visible in status bits 7:4 in the cycle after the character, read or command involved. The reference model compares every output on every clock, so the first wrong cycle is reported.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic brk;
        logic fe;
        logic pe;
    } rx_flags_t;

    localparam logic [1:0] PAR_CHECK = 2'b00;
    localparam logic [1:0] PAR_FORCE = 2'b01;
    localparam logic [1:0] PAR_NONE  = 2'b10;
    localparam logic [1:0] PAR_MDROP = 2'b11;

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              tick,
    input  logic              rxd,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par_mode,
    input  logic              cfg_par_odd,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output rx_flags_t         out_flags
);
    localparam int CW   = $clog2(OSR);
    localparam int BW   = $clog2(DATA_W);
    localparam int HALF = OSR / 2 - 1;

    rx_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     idx_q;
    logic [BW-1:0]     last_idx;
    logic [DATA_W-1:0] shf_q;
    logic              par_q;
    logic              mid, centre, uses_par;
    logic              pe_c, brk_c;

    assign last_idx = BW'(3'd4 + 3'(cfg_len));
    assign uses_par = (cfg_par_mode != PAR_NONE);
    assign mid      = tick && (cnt_q == CW'(HALF));
    assign centre   = tick && (cnt_q == CW'(OSR - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (tick && !rxd) state_d = RX_START;
            RX_START:  if (mid) state_d = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:   if (centre && idx_q == last_idx) state_d = uses_par ? RX_PARITY : RX_STOP;
            RX_PARITY: if (centre) state_d = RX_STOP;
            RX_STOP:   if (centre) state_d = rxd ? RX_IDLE : RX_HOLD;
            RX_HOLD:   if (tick && rxd) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= RX_IDLE;
        else if (flush)  state_q <= RX_IDLE;
        else             state_q <= state_d;
    end

    // flag evaluation at the stop-bit centre
    always_comb begin
        unique case (cfg_par_mode)
            PAR_CHECK: pe_c = par_q != ((^shf_q) ^ cfg_par_odd);
            PAR_FORCE: pe_c = par_q != cfg_par_odd;
            PAR_MDROP: pe_c = par_q;
            default:   pe_c = 1'b0;
        endcase
        brk_c = !rxd && (shf_q == '0) && !(uses_par && par_q);
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            shf_q     <= '0;
            par_q     <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_flags <= '0;
        end else begin
            out_valid <= 1'b0;
            if (flush) begin
                cnt_q <= '0;
                idx_q <= '0;
            end else begin
                if (tick) begin
                    if (state_q == RX_IDLE || state_q == RX_HOLD ||
                        (state_q == RX_START && mid) || centre)
                        cnt_q <= '0;
                    else
                        cnt_q <= cnt_q + 1'b1;
                end
                if (state_q == RX_START && mid) begin
                    idx_q <= '0;
                    shf_q <= '0;
                    par_q <= 1'b0;
                end
                if (state_q == RX_DATA && centre) begin
                    shf_q[idx_q] <= rxd;
                    idx_q        <= idx_q + 1'b1;
                end
                if (state_q == RX_PARITY && centre)
                    par_q <= rxd;
                if (state_q == RX_STOP && centre) begin
                    out_valid <= 1'b1;
                    out_data  <= shf_q;
                    out_flags <= '{brk: brk_c, fe: !rxd, pe: pe_c};
                end
            end
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty,
    output logic         accepted
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_pop, do_push;

    assign full     = (cnt_q == CW'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign do_pop   = pop && !empty;
    assign do_push  = push && (!full || do_pop);
    assign accepted = do_push;
    assign dout     = slot[rd_q];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            slot[i] <= '0;
            else if (do_push && wr_q == PW'(i))    slot[i] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/uart_rx_chan.sv
module uart_rx_chan
    import uart_rx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par_mode,
    input  logic              cfg_par_odd,
    input  logic              cfg_blk_mode,
    input  logic              cfg_irq_full,
    input  logic              rd_en,
    input  logic              cmd_err_clr,
    input  logic              cmd_rx_rst,
    output logic [DATA_W-1:0] rd_data,
    output logic [7:0]        status,
    output logic              rx_irq
);
    localparam int FW = $bits(rx_flags_t);
    localparam int EW = DATA_W + FW;

    logic              frm_valid;
    logic [DATA_W-1:0] frm_data;
    rx_flags_t         frm_flags;
    logic [EW-1:0]     head;
    logic              q_full, q_empty, q_acc;
    logic              ovf_hit, ovr_q;
    rx_flags_t         acc_q, head_flags, shown;

    uart_rx_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (cmd_rx_rst),
        .tick         (tick16),
        .rxd          (rxd),
        .cfg_len      (cfg_len),
        .cfg_par_mode (cfg_par_mode),
        .cfg_par_odd  (cfg_par_odd),
        .out_valid    (frm_valid),
        .out_data     (frm_data),
        .out_flags    (frm_flags)
    );

    uart_rx_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (cmd_rx_rst),
        .push     (frm_valid),
        .pop      (rd_en),
        .din      ({frm_flags, frm_data}),
        .dout     (head),
        .full     (q_full),
        .empty    (q_empty),
        .accepted (q_acc)
    );

    assign ovf_hit = frm_valid && !q_acc;

    // sticky error state: a new event in the clear cycle survives the clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            acc_q <= '0;
        end else if (cmd_rx_rst) begin
            ovr_q <= 1'b0;
            acc_q <= '0;
        end else begin
            ovr_q <= (cmd_err_clr ? 1'b0 : ovr_q) | ovf_hit;
            acc_q <= (cmd_err_clr ? rx_flags_t'('0) : acc_q) |
                     (q_acc ? frm_flags : rx_flags_t'('0));
        end
    end

    assign head_flags = q_empty ? rx_flags_t'('0) : rx_flags_t'(head[EW-1 -: FW]);
    assign shown      = cfg_blk_mode ? acc_q : head_flags;
    assign rd_data    = q_empty ? '0 : head[DATA_W-1:0];
    assign status     = {shown.brk, shown.fe, shown.pe, ovr_q, 2'b00, q_full, !q_empty};
    assign rx_irq     = cfg_irq_full ? q_full : !q_empty;

endmodule

// File: rtl/uart_rx_chan_chk.sv
module uart_rx_chan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_err_clr,
    input logic       cmd_rx_rst,
    input logic       cfg_blk_mode,
    input logic       frm_valid,
    input logic [7:0] status
);
    // R2: a completed frame is reported for exactly one cycle
    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid);

    // R6: overrun can only appear while the queue is full
    assert_ovr_on_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> status[1]);

    // R7: a full queue always has a ready character
    assert_full_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> status[0]);

    // R9: accumulated flags drop only through a command
    assert_block_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_blk_mode && $past(cfg_blk_mode) && (($past(status[7:5]) & ~status[7:5]) != 3'b000))
        |-> $past(cmd_err_clr || cmd_rx_rst));

    // R10: receiver reset leaves an empty, error-free status
    assert_rx_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rx_rst |=> (status == 8'h00));
endmodule

bind uart_rx_chan uart_rx_chan_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_err_clr  (cmd_err_clr),
    .cmd_rx_rst   (cmd_rx_rst),
    .cfg_blk_mode (cfg_blk_mode),
    .frm_valid    (frm_valid),
    .status       (status)
);

// File: tb/uart_rx_chan_test.sv
module uart_rx_chan_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic [1:0] cfg_par_mode = 2'b10;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_blk_mode = 1'b0;
    logic       cfg_irq_full = 1'b0;
    logic       rd_en = 1'b0;
    logic       cmd_err_clr = 1'b0;
    logic       cmd_rx_rst = 1'b0;
    logic [7:0] rd_data, status;
    logic       rx_irq;

    int errors = 0;
    int checks = 0;
    int ecount = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) ecount <= ecount + 1;

    uart_rx_chan uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_mode(cfg_par_mode), .cfg_par_odd(cfg_par_odd),
        .cfg_blk_mode(cfg_blk_mode), .cfg_irq_full(cfg_irq_full),
        .rd_en(rd_en), .cmd_err_clr(cmd_err_clr), .cmd_rx_rst(cmd_rx_rst),
        .rd_data(rd_data), .status(status), .rx_irq(rx_irq)
    );

    // reference model state
    logic [7:0] qd[$];
    logic [2:0] qf[$];
    logic       m_ovr = 1'b0;
    logic [2:0] m_acc = 3'b000;
    int         push_at = -1, pop_at = -1, clr_at = -1, rrst_at = -1;
    logic [7:0] push_d;
    logic [2:0] push_f;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at edge %0d", tag, act, exp, ecount);
        end
    endtask

    // per-clock reference comparison
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            logic [2:0] shown;
            if (ecount == rrst_at) begin
                qd.delete(); qf.delete(); m_ovr = 1'b0; m_acc = 3'b000;
            end else begin
                if (ecount == clr_at) begin m_ovr = 1'b0; m_acc = 3'b000; end
                if (ecount == pop_at && qd.size() > 0) begin
                    void'(qd.pop_front()); void'(qf.pop_front());
                end
                if (ecount == push_at) begin
                    if (qd.size() >= 4) m_ovr = 1'b1;
                    else begin qd.push_back(push_d); qf.push_back(push_f); m_acc |= push_f; end
                end
            end
            shown = cfg_blk_mode ? m_acc : (qd.size() > 0 ? qf[0] : 3'b000);
            check("R7 status model", status,
                  {shown, m_ovr, 2'b00, qd.size() == 4, qd.size() > 0});
            check("R5 rd_data model", rd_data, qd.size() > 0 ? qd[0] : 8'h00);
            check("R11 irq model", {7'b0, rx_irq},
                  {7'b0, cfg_irq_full ? qd.size() == 4 : qd.size() > 0});
        end
    end

    function automatic logic [2:0] exp_flags(input logic [7:0] d, input logic pb, input logic stopv);
        logic pe, fe, brk, ones;
        bit haspar;
        haspar = (cfg_par_mode != 2'b10);
        ones = ^d;
        case (cfg_par_mode)
            2'b00:   pe = pb != (ones ^ cfg_par_odd);
            2'b01:   pe = pb != cfg_par_odd;
            2'b11:   pe = pb;
            default: pe = 1'b0;
        endcase
        fe = !stopv;
        brk = fe && (d == 8'h00) && !(haspar && pb);
        return {brk, fe, pe};
    endfunction

    task automatic send(input logic [7:0] din, input logic pb, input logic stopv);
        int n, e0, hp;
        logic [7:0] d;
        n = 5 + int'(cfg_len);
        hp = (cfg_par_mode != 2'b10) ? 1 : 0;
        d = din & 8'((9'h100 >> (8 - n)) - 1);
        @(negedge clk);
        rxd = 1'b0;
        e0 = ecount + 1;
        push_d = d;
        push_f = exp_flags(d, pb, stopv);
        push_at = e0 + 9 + 16 * (n + hp + 1);
        repeat (16) @(negedge clk);
        for (int i = 0; i < n; i++) begin rxd = din[i]; repeat (16) @(negedge clk); end
        if (hp == 1) begin rxd = pb; repeat (16) @(negedge clk); end
        rxd = stopv;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic rd();
        @(negedge clk);
        rd_en = 1'b1; pop_at = ecount + 1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic err_clr();
        @(negedge clk);
        cmd_err_clr = 1'b1; clr_at = ecount + 1;
        @(negedge clk);
        cmd_err_clr = 1'b0;
    endtask

    task automatic rx_rst();
        @(negedge clk);
        cmd_rx_rst = 1'b1; rrst_at = ecount + 1;
        @(negedge clk);
        cmd_rx_rst = 1'b0;
    endtask

    task automatic expect8(input string tag, input logic [7:0] act_now_sel, input logic [7:0] exp);
        check(tag, act_now_sel, exp);
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        expect8("R1 reset status", status, 8'h00);
        expect8("R1 reset irq", {7'b0, rx_irq}, 8'h00);
        expect8("R1 reset data", rd_data, 8'h00);

        // R2 8-bit, no parity
        send(8'hA5, 1'b0, 1'b1);
        settle();
        expect8("R2 8-bit data", rd_data, 8'hA5);
        expect8("R7 ready only", status, 8'h01);
        rd();

        // R3 5-bit even parity, good then bad
        cfg_len = 2'b00; cfg_par_mode = 2'b00; cfg_par_odd = 1'b0;
        send(8'h16, 1'b1, 1'b1);
        settle();
        expect8("R3 even good", status, 8'h01);
        expect8("R2 5-bit data", rd_data, 8'h16);
        rd();
        send(8'h16, 1'b0, 1'b1);
        settle();
        expect8("R3 even bad", status[7:5], 8'h01);
        rd();
        settle();
        expect8("R8 flags gone after read", status[7:5], 8'h00);

        // R3 7-bit odd parity, upper bit masked
        cfg_len = 2'b10; cfg_par_odd = 1'b1;
        send(8'hD5, 1'b1, 1'b1);
        settle();
        expect8("R2 7-bit masked", rd_data, 8'h55);
        expect8("R3 odd good", status[7:5], 8'h00);
        rd();

        // R3 forced parity
        cfg_len = 2'b11; cfg_par_mode = 2'b01; cfg_par_odd = 1'b1;
        send(8'h3C, 1'b0, 1'b1);
        settle();
        expect8("R3 force mismatch", status[7:5], 8'h01);
        rd();
        send(8'h3C, 1'b1, 1'b1);
        settle();
        expect8("R3 force match", status[7:5], 8'h00);
        rd();

        // R3 multidrop address marker
        cfg_par_mode = 2'b11;
        send(8'h42, 1'b1, 1'b1);
        settle();
        expect8("R3 multidrop address", status[7:5], 8'h01);
        rd();

        // R4 framing error and break
        cfg_par_mode = 2'b10; cfg_par_odd = 1'b0;
        send(8'h3C, 1'b0, 1'b0);
        settle();
        expect8("R4 framing", status[7:5], 8'h02);
        rd();
        send(8'h00, 1'b0, 1'b0);
        settle();
        expect8("R4 break", status[7:5], 8'h06);
        expect8("R4 single break char", status[1:0], 8'h01);
        rd();

        // R12 glitch rejection
        @(negedge clk);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        settle();
        expect8("R12 glitch ignored", status, 8'h00);

        // R5 read while empty
        rd();
        settle();
        expect8("R5 empty read status", status, 8'h00);
        expect8("R5 empty read data", rd_data, 8'h00);

        // R6 / R11 overrun and interrupt selection
        send(8'h01, 1'b0, 1'b1);
        settle();
        expect8("R11 irq on ready", {7'b0, rx_irq}, 8'h01);
        cfg_irq_full = 1'b1;
        settle();
        expect8("R11 irq waits for full", {7'b0, rx_irq}, 8'h00);
        send(8'h02, 1'b0, 1'b1);
        send(8'h03, 1'b0, 1'b1);
        send(8'h04, 1'b0, 1'b1);
        settle();
        expect8("R5 full flag", status[1:0], 8'h03);
        expect8("R11 irq on full", {7'b0, rx_irq}, 8'h01);
        send(8'h05, 1'b0, 1'b1);
        settle();
        expect8("R6 overrun set", status[4], 1'b1);
        for (int k = 1; k <= 4; k++) begin
            settle();
            expect8("R6 contents kept", rd_data, 8'(k));
            rd();
        end
        settle();
        expect8("R6 overrun sticky", status, 8'h10);
        err_clr();
        settle();
        expect8("R6 overrun cleared", status, 8'h00);
        cfg_irq_full = 1'b0;

        // R9 block mode accumulation
        cfg_blk_mode = 1'b1; cfg_par_mode = 2'b00; cfg_par_odd = 1'b0;
        send(8'h03, 1'b1, 1'b1);
        send(8'h81, 1'b0, 1'b1);
        send(8'h7E, 1'b0, 1'b0);
        settle();
        expect8("R9 accumulated", status[7:5], 8'h03);
        rd(); rd(); rd();
        settle();
        expect8("R9 kept after reads", status, 8'h60);
        err_clr();
        settle();
        expect8("R9 cleared", status, 8'h00);
        cfg_blk_mode = 1'b0;

        // R10 receiver reset
        cfg_par_mode = 2'b10;
        send(8'h11, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b1);
        settle();
        expect8("R10 before reset", status, 8'h03 & 8'h01);
        rx_rst();
        settle();
        expect8("R10 status flushed", status, 8'h00);
        expect8("R10 data flushed", rd_data, 8'h00);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule